// File: doc/BRIEF.md
# Address-Match Breakpoint Controller

This block is a debug peripheral for a small 8-bit processor. Software loads a 16-bit break address through two byte registers and sets an enable bit. The block then compares that address on every clock against the processor's internal address bus. On a hit it raises the break-active flag and a pending breakpoint request. A software-break input raises the same pending request.

The processor only honours the request at an instruction boundary. The block therefore holds the request until an instruction-complete strobe arrives, and then emits a one-cycle take pulse. At that point the core substitutes its software-interrupt opcode. The block also presents the interrupt vector address the core should fetch, which depends on whether the part runs in monitor mode.

While a break is active, the block holds the watchdog off. Status flags can be cleared by software only when a separate flag-clear enable bit is set.

The register interface is a byte-wide bus with a full 16-bit register address and a write strobe. Read data is registered: the value for the address presented in one cycle appears after the next rising edge.

Top module: `brkpt_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads 0, `brk_req`, `brk_take` and `cop_disable` are 0, and `vec_addr` is 16'hFFFC.
- R2: Address 16'hFE0C holds break-address bits 15..8 and 16'hFE0D holds bits 7..0. Both are read/write. Read data for the address on `reg_addr` appears on `reg_rdata` one clock later. Unmapped addresses read 0.
- R3: At 16'hFE0E, bit 7 is a read/write break enable and bit 6 is the break-active flag. Bits 5..0 always read 0.
- R4: When the enable is 1 and `cpu_addr` equals the break address at a rising edge, the active flag and the pending request are set at that edge. With the enable at 0, an equal address has no effect.
- R5: A high `sw_break` at a rising edge sets the pending request whatever the enable, and leaves the active flag untouched.
- R6: `brk_req` shows the pending request. It stays set until an edge at which it is set and `instr_done` is 1. At that edge it clears, unless a new request arrives in the same cycle, in which case it stays set. `brk_take` is 1 for exactly the cycle after such an edge.
- R7: Writing 16'hFE0E with bit 6 at 0 clears the active flag only when the flag-clear enable (bit 7 of 16'hFE03, read/write) is 1. Otherwise the write leaves the flag unchanged. Writing 1 to bit 6 never sets it. An address hit in the same cycle as a clear wins.
- R8: Bit 1 of 16'hFE00 is the break-wait flag. It is set when a break is taken (the R6 take edge) while `in_wait` is 1. Writing 0 to it clears it only when the flag-clear enable is 1. Writing 1 has no effect. Other bits read 0.
- R9: `cop_disable` equals the break-active flag in every cycle.
- R10: `vec_addr` is registered. It is 16'hFEFC one clock after `monitor_mode` is 1 and 16'hFFFC one clock after it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 16 | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's address |
| cpu_addr | input | 16 | Processor internal address bus |
| instr_done | input | 1 | Instruction-boundary strobe |
| in_wait | input | 1 | Processor is in its wait state |
| sw_break | input | 1 | Software-generated break request |
| monitor_mode | input | 1 | Monitor mode selects the alternate vector |
| brk_req | output | 1 | Pending breakpoint request |
| brk_take | output | 1 | One-cycle pulse: break taken at an instruction boundary |
| vec_addr | output | 16 | Vector address to fetch (high byte location) |
| cop_disable | output | 1 | Holds the watchdog off while a break is active |

## Verification
The bench targets several corner cases, each with a distinct failure symptom:

- **Deferral.** A hit is held through many cycles without `instr_done`. A design that fired at once would pulse `brk_take` early; one that dropped the request would never pulse it.
- **Hit during clear.** A hit lands in the same cycle as a software clear. Wrong priority would leave the active flag and `cop_disable` low.
- **Clears with gating off.** Clears of both flags are attempted with the flag-clear enable at 0 and at 1. Missing gating would show in the read-back data.
- **Request at the take edge.** A new request arrives exactly at a take edge. It must leave `brk_req` high.
- **Disabled comparator.** A matching address with the enable off must not raise anything.
- **Vector switching.** Toggling `monitor_mode` exercises both vector values.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;
  // Register offsets from the block's base address
  localparam int OFS_BSTAT   = 'h00;
  localparam int OFS_FLAGCTL = 'h03;
  localparam int OFS_BADDR   = 'h0C;  // high byte; low byte follows
  localparam int OFS_CTRL    = 'h0E;

  // Bit positions inside the byte registers
  localparam int BIT_WAIT    = 1;  // break-wait flag in status register
  localparam int BIT_CLREN   = 7;  // flag-clear enable
  localparam int BIT_EN      = 7;  // break enable
  localparam int BIT_ACT     = 6;  // break-active flag
endpackage

// File: rtl/brkpt_match.sv
module brkpt_match #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [ADDR_W-1:0] brk_addr,
  input  logic              brk_en,
  input  logic              sw_break,
  output logic              hit,
  output logic              req
);
  localparam int NLANE = ADDR_W / DATA_W;

  logic [NLANE-1:0] lane_eq;

  // Byte-lane comparators, reduced with an AND tree
  for (genvar i = 0; i < NLANE; i++) begin : g_cmp
    assign lane_eq[i] = cpu_addr[i*DATA_W +: DATA_W] == brk_addr[i*DATA_W +: DATA_W];
  end

  assign hit = brk_en && (&lane_eq);
  assign req = hit || sw_break;
endmodule

// File: rtl/brkpt_regs.sv
module brkpt_regs
  import brkpt_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              hit,
  input  logic              wait_take,
  output logic [ADDR_W-1:0] brk_addr,
  output logic              brk_en,
  output logic              brk_act
);
  localparam int NLANE = ADDR_W / DATA_W;
  localparam logic [ADDR_W-1:0] A_STAT = REG_BASE + ADDR_W'(OFS_BSTAT);
  localparam logic [ADDR_W-1:0] A_FLAG = REG_BASE + ADDR_W'(OFS_FLAGCTL);
  localparam logic [ADDR_W-1:0] A_CTRL = REG_BASE + ADDR_W'(OFS_CTRL);

  logic sel_stat, sel_flag, sel_ctrl;
  logic [NLANE-1:0] sel_lane;
  logic [NLANE-1:0][DATA_W-1:0] addr_q;
  logic en_q, act_q, clren_q, wait_q;
  logic [DATA_W-1:0] rd_nxt;

  assign sel_stat = reg_addr == A_STAT;
  assign sel_flag = reg_addr == A_FLAG;
  assign sel_ctrl = reg_addr == A_CTRL;

  // Address lanes: most significant lane sits at the lowest offset
  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam logic [ADDR_W-1:0] A_LANE = REG_BASE + ADDR_W'(OFS_BADDR + (NLANE - 1 - i));
    assign sel_lane[i] = reg_addr == A_LANE;
    always_ff @(posedge clk) begin
      if (rst)                      addr_q[i] <= '0;
      else if (reg_wr && sel_lane[i]) addr_q[i] <= reg_wdata;
    end
  end

  assign brk_addr = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      act_q   <= 1'b0;
      clren_q <= 1'b0;
      wait_q  <= 1'b0;
    end else begin
      if (reg_wr && sel_ctrl) en_q <= reg_wdata[BIT_EN];
      if (reg_wr && sel_flag) clren_q <= reg_wdata[BIT_CLREN];
      // hardware set beats a software clear in the same cycle
      if (hit)
        act_q <= 1'b1;
      else if (reg_wr && sel_ctrl && !reg_wdata[BIT_ACT] && clren_q)
        act_q <= 1'b0;
      if (wait_take)
        wait_q <= 1'b1;
      else if (reg_wr && sel_stat && !reg_wdata[BIT_WAIT] && clren_q)
        wait_q <= 1'b0;
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (sel_stat) rd_nxt[BIT_WAIT] = wait_q;
    if (sel_flag) rd_nxt[BIT_CLREN] = clren_q;
    if (sel_ctrl) begin
      rd_nxt[BIT_EN]  = en_q;
      rd_nxt[BIT_ACT] = act_q;
    end
    for (int i = 0; i < NLANE; i++)
      if (sel_lane[i]) rd_nxt = addr_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_nxt;
  end

  assign brk_en  = en_q;
  assign brk_act = act_q;

  assert_hit_sets_act_R4: assert property (@(posedge clk) disable iff (rst)
    hit |=> act_q);
  assert_act_clear_gated_R7: assert property (@(posedge clk) disable iff (rst)
    act_q && !clren_q |=> act_q);
  assert_wait_clear_gated_R8: assert property (@(posedge clk) disable iff (rst)
    wait_q && !clren_q |=> wait_q);
  assert_wait_sets_R8: assert property (@(posedge clk) disable iff (rst)
    wait_take |=> wait_q);
endmodule

// File: rtl/brkpt_defer.sv
module brkpt_defer #(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] VEC_STD = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_MON = 16'hFEFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              instr_done,
  input  logic              monitor_mode,
  output logic              pend,
  output logic              take_now,
  output logic              take,
  output logic [ADDR_W-1:0] vec_addr
);
  logic pend_q, take_q;
  logic [ADDR_W-1:0] vec_q;

  assign take_now = pend_q && instr_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      take_q <= 1'b0;
      vec_q  <= VEC_STD;
    end else begin
      // a fresh request outranks retirement at the boundary
      if (req)           pend_q <= 1'b1;
      else if (take_now) pend_q <= 1'b0;
      take_q <= take_now;
      vec_q  <= monitor_mode ? VEC_MON : VEC_STD;
    end
  end

  assign pend     = pend_q;
  assign take     = take_q;
  assign vec_addr = vec_q;

  assert_req_pends_R5: assert property (@(posedge clk) disable iff (rst)
    req |=> pend_q);
  assert_pend_held_R6: assert property (@(posedge clk) disable iff (rst)
    pend_q && !instr_done |=> pend_q);
  assert_take_cause_R6: assert property (@(posedge clk) disable iff (rst)
    take_q |-> $past(pend_q && instr_done));
  assert_vec_mon_R10: assert property (@(posedge clk) disable iff (rst)
    monitor_mode |=> vec_q == VEC_MON);
endmodule

// File: rtl/brkpt_ctrl.sv
module brkpt_ctrl #(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'hFE00,
  parameter logic [ADDR_W-1:0] VEC_STD  = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_MON  = 16'hFEFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              instr_done,
  input  logic              in_wait,
  input  logic              sw_break,
  input  logic              monitor_mode,
  output logic              brk_req,
  output logic              brk_take,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              cop_disable
);
  logic [ADDR_W-1:0] brk_addr;
  logic brk_en, brk_act, hit, req, take_now, wait_take;

  assign wait_take = take_now && in_wait;

  brkpt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_BASE(REG_BASE)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hit(hit),
    .wait_take(wait_take), .brk_addr(brk_addr), .brk_en(brk_en),
    .brk_act(brk_act)
  );

  brkpt_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .cpu_addr(cpu_addr), .brk_addr(brk_addr), .brk_en(brk_en),
    .sw_break(sw_break), .hit(hit), .req(req)
  );

  brkpt_defer #(.ADDR_W(ADDR_W), .VEC_STD(VEC_STD), .VEC_MON(VEC_MON)) u_defer (
    .clk(clk), .rst(rst), .req(req), .instr_done(instr_done),
    .monitor_mode(monitor_mode), .pend(brk_req), .take_now(take_now),
    .take(brk_take), .vec_addr(vec_addr)
  );

  // watchdog hold-off follows the active flag register directly
  assign cop_disable = brk_act;

  assert_take_clears_R6: assert property (@(posedge clk) disable iff (rst)
    take_now && !req |=> !brk_req);
endmodule

// File: tb/brkpt_ctrl_test.sv
module brkpt_ctrl_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rst, reg_wr, instr_done, in_wait, sw_break, monitor_mode;
  logic [15:0] reg_addr, cpu_addr, vec_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic brk_req, brk_take, cop_disable;

  brkpt_ctrl uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
    .instr_done(instr_done), .in_wait(in_wait), .sw_break(sw_break),
    .monitor_mode(monitor_mode), .brk_req(brk_req), .brk_take(brk_take),
    .vec_addr(vec_addr), .cop_disable(cop_disable)
  );

  int n_chk = 0, n_fail = 0;
  bit live = 0, done = 0;

  // behavioural reference state
  logic [15:0] m_addr = '0, m_vec = 16'hFFFC;
  logic m_en = 0, m_act = 0, m_clr = 0, m_wait = 0, m_pend = 0, m_take = 0;
  logic [7:0] m_rd = '0;

  always @(posedge clk) begin : model
    logic hit, tk;
    logic [7:0] rd;
    hit = m_en && (cpu_addr == m_addr);
    tk  = m_pend && instr_done;
    case (reg_addr)
      16'hFE00: rd = {6'b0, m_wait, 1'b0};
      16'hFE03: rd = {m_clr, 7'b0};
      16'hFE0C: rd = m_addr[15:8];
      16'hFE0D: rd = m_addr[7:0];
      16'hFE0E: rd = {m_en, m_act, 6'b0};
      default:  rd = 8'h00;
    endcase
    if (rst) begin
      m_addr <= '0; m_en <= 0; m_act <= 0; m_clr <= 0; m_wait <= 0;
      m_pend <= 0; m_take <= 0; m_rd <= 0; m_vec <= 16'hFFFC;
    end else begin
      m_rd <= rd;
      if (reg_wr && reg_addr == 16'hFE0C) m_addr[15:8] <= reg_wdata;
      if (reg_wr && reg_addr == 16'hFE0D) m_addr[7:0] <= reg_wdata;
      if (reg_wr && reg_addr == 16'hFE0E) m_en <= reg_wdata[7];
      if (reg_wr && reg_addr == 16'hFE03) m_clr <= reg_wdata[7];
      if (hit) m_act <= 1;
      else if (reg_wr && reg_addr == 16'hFE0E && !reg_wdata[6] && m_clr) m_act <= 0;
      if (tk && in_wait) m_wait <= 1;
      else if (reg_wr && reg_addr == 16'hFE00 && !reg_wdata[1] && m_clr) m_wait <= 0;
      if (hit || sw_break) m_pend <= 1;
      else if (tk) m_pend <= 0;
      m_take <= tk;
      m_vec <= monitor_mode ? 16'hFEFC : 16'hFFFC;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) if (live && !done) begin
    chk("R2 R3 R7 R8 read data", {8'h0, reg_rdata}, {8'h0, m_rd});
    chk("R4 R5 R6 brk_req", {15'h0, brk_req}, {15'h0, m_pend});
    chk("R6 brk_take", {15'h0, brk_take}, {15'h0, m_take});
    chk("R10 vec_addr", vec_addr, m_vec);
    chk("R9 cop_disable", {15'h0, cop_disable}, {15'h0, m_act});
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    cyc(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a;
    cyc(1);
    chk(tag, {8'h0, reg_rdata}, {8'h0, exp});
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst = 1; reg_wr = 0; reg_addr = 16'h0000; reg_wdata = 0; cpu_addr = 16'h0000;
    instr_done = 0; in_wait = 0; sw_break = 0; monitor_mode = 0;
    cyc(3);
    live = 1;
    // R1: reset values
    chk("R1 reset brk_req", {15'h0, brk_req}, 16'h0);
    chk("R1 reset vec_addr", vec_addr, 16'hFFFC);
    chk("R1 reset cop_disable", {15'h0, cop_disable}, 16'h0);
    rst = 0;
    rd(16'hFE0E, 8'h00, "R1 control after reset");
    // R2: address bytes and unmapped reads
    wr(16'hFE0C, 8'h12);
    wr(16'hFE0D, 8'h34);
    rd(16'hFE0C, 8'h12, "R2 high byte");
    rd(16'hFE0D, 8'h34, "R2 low byte");
    rd(16'hFE05, 8'h00, "R2 unmapped");
    // R4: disabled comparator ignores the match
    cpu_addr = 16'h1234;
    cyc(3);
    chk("R4 disabled no request", {15'h0, brk_req}, 16'h0);
    cpu_addr = 16'h0000;
    // R3: enable, low bits read zero
    wr(16'hFE0E, 8'h3F | 8'h80);
    rd(16'hFE0E, 8'h80, "R3 enable only");
    // R4 + R6: hit, then deferred take
    cpu_addr = 16'h1234; cyc(1); cpu_addr = 16'h0000;
    cyc(5);
    chk("R6 held while no boundary", {15'h0, brk_req}, 16'h1);
    chk("R4 active flag via cop", {15'h0, cop_disable}, 16'h1);
    instr_done = 1; cyc(1); instr_done = 0;
    chk("R6 take pulse", {15'h0, brk_take}, 16'h1);
    cyc(1);
    chk("R6 take one cycle", {15'h0, brk_take}, 16'h0);
    // R7: clear gated by flag-clear enable
    wr(16'hFE0E, 8'h80);
    rd(16'hFE0E, 8'hC0, "R7 clear ignored without enable");
    wr(16'hFE03, 8'h80);
    rd(16'hFE03, 8'h80, "R7 clear enable readback");
    wr(16'hFE0E, 8'h80);
    rd(16'hFE0E, 8'h80, "R7 clear accepted");
    // R7: hit in same cycle as clear wins
    cpu_addr = 16'h1234; wr(16'hFE0E, 8'h80); cpu_addr = 16'h0000;
    rd(16'hFE0E, 8'hC0, "R7 set wins over clear");
    instr_done = 1; cyc(1); instr_done = 0;
    // R5 + R8: software break taken in wait
    sw_break = 1; cyc(1); sw_break = 0;
    in_wait = 1; instr_done = 1; sw_break = 1; cyc(1);
    sw_break = 0; instr_done = 0; in_wait = 0;
    chk("R6 new request at take edge keeps pending", {15'h0, brk_req}, 16'h1);
    rd(16'hFE00, 8'h02, "R8 wait flag set");
    wr(16'hFE00, 8'h02);
    rd(16'hFE00, 8'h02, "R8 writing one no effect");
    wr(16'hFE00, 8'h00);
    rd(16'hFE00, 8'h00, "R8 cleared");
    instr_done = 1; in_wait = 1; cyc(1); instr_done = 0; in_wait = 0;
    wr(16'hFE03, 8'h00);
    wr(16'hFE00, 8'h00);
    rd(16'hFE00, 8'h02, "R8 clear ignored without enable");
    // R10: vector follows monitor mode
    monitor_mode = 1; cyc(2);
    chk("R10 monitor vector", vec_addr, 16'hFEFC);
    monitor_mode = 0; cyc(2);
    chk("R10 normal vector", vec_addr, 16'hFFFC);
    // Mixed random traffic compared cycle by cycle against the model
    for (int i = 0; i < 4000; i++) begin
      case ($urandom % 6)
        0: reg_addr = 16'hFE00;
        1: reg_addr = 16'hFE03;
        2: reg_addr = 16'hFE0C;
        3: reg_addr = 16'hFE0D;
        4: reg_addr = 16'hFE0E;
        default: reg_addr = 16'hFE07;
      endcase
      reg_wr       = ($urandom % 4) == 0;
      reg_wdata    = 8'($urandom);
      cpu_addr     = (($urandom % 3) == 0) ? m_addr : 16'($urandom);
      instr_done   = ($urandom % 3) == 0;
      sw_break     = ($urandom % 16) == 0;
      in_wait      = ($urandom % 2) == 0;
      monitor_mode = ($urandom % 5) == 0;
      cyc(1);
    end
    reg_wr = 0;
    cyc(2);
    finish_run();
  end
endmodule